// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block holds the three fault-reporting registers of one side of a memory management unit: a status word, a tag-access register and, on the data side only, a fault address register. Another unit decides that a fault has happened and what kind it is. It then raises a single-cycle pulse together with the fault attributes: a write flag, a 2-bit context type, a side-effect flag, a fault code and an 8-bit address space number. The same pulse carries a miss flag, the faulting address and the active context.

On each pulse the status word is rebuilt from the attributes. Its low two bits remember whether an earlier fault was still pending. On a miss, the tag-access register takes the virtual page number and the context. A data-side instance also latches the complete faulting address.

Software reads and writes all three registers through a small select/write-enable port. A software write to a register takes precedence over a fault update to that same register in the same cycle. The parameter `DATA_SIDE` selects which side the instance serves.

Top module: `mmu_fault_recorder`

## Requirements
- R1: After reset, the status, tag-access and fault address registers all read as zero.
- R2: A fault recorded while status bit 0 is clear sets status bits 1:0 to 2'b01.
- R3: A fault recorded while status bit 0 is set sets status bits 1:0 to 2'b11, marking an overflow.
- R4: A recorded fault places the fields as follows: the write flag in bit 2, the context type in bits 5:4, the side-effect flag in bit 6, the fault code in bits 13:7 and the address space number in bits 23:16. Bits 3, 15:14 and 63:24 are zero.
- R5: Recording a fault clears every status bit that the new fault does not set, whatever the previous status word held.
- R6: A fault with the miss flag set loads the tag-access register with address bits 63:13 in place and the 13-bit context in bits 12:0. A fault without the miss flag leaves the register unchanged.
- R7: In a data-side instance (`DATA_SIDE`=1), every fault loads the whole faulting address into the fault address register. In an instruction-side instance that register always reads zero.
- R8: Register select encoding: 0 is status, 1 is tag-access, 2 is fault address, and 3 is unused. A software write loads the selected register on the next clock edge. Reads return the selected register combinationally. Select 3 reads zero and ignores writes.
- R9: When a software write to a register and a fault update to that same register fall in the same cycle, the register takes the software data. Registers that are not written by software still take the fault update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_pulse | input | 1 | One-cycle fault record strobe |
| flt_write | input | 1 | Faulting access was a store |
| flt_ctx_type | input | 2 | Context type of the access |
| flt_side_eff | input | 1 | Side-effect flag |
| flt_code | input | 7 | Fault type code |
| flt_space | input | 8 | Address space number |
| flt_miss | input | 1 | Fault was a translation miss |
| flt_addr | input | 64 | Faulting virtual address |
| flt_ctx | input | 13 | Context number of the access |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Software write enable |
| reg_wdata | input | 64 | Software write data |
| reg_rdata | output | 64 | Selected register contents |

## Verification
A wrong pending bit does not show up at once. It appears only when the next fault arrives, as a missing or spurious overflow in status bit 1, readable in the cycle after that fault. For this reason the bench always issues faults in pairs. A misplaced field or a stale bit is visible on the status read one cycle after the pulse. A tag register that updates on a non-miss fault, or that fails to update on a miss, shows up on the very next tag read. Priority errors are exposed by a fault that coincides with a software write, where the software value must win.

// File: rtl/mmu_fault_recorder.sv
module mmu_fault_recorder #(
  parameter int AW        = 64,
  parameter int PAGE_LSB  = 13,
  parameter int CODE_W    = 7,
  parameter int SPACE_W   = 8,
  parameter bit DATA_SIDE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flt_pulse,
  input  logic                flt_write,
  input  logic [1:0]          flt_ctx_type,
  input  logic                flt_side_eff,
  input  logic [CODE_W-1:0]   flt_code,
  input  logic [SPACE_W-1:0]  flt_space,
  input  logic                flt_miss,
  input  logic [AW-1:0]       flt_addr,
  input  logic [PAGE_LSB-1:0] flt_ctx,
  input  logic [1:0]          reg_sel,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_wdata,
  output logic [AW-1:0]       reg_rdata
);
  localparam int POS_CT    = 4;
  localparam int POS_CODE  = 7;
  localparam int POS_SPACE = 16;

  logic [AW-1:0] status_q, tag_q, faddr_q, status_next;
  logic sw_status, sw_tag, sw_faddr;

  assign sw_status = reg_we && reg_sel == 2'd0;
  assign sw_tag    = reg_we && reg_sel == 2'd1;
  assign sw_faddr  = reg_we && reg_sel == 2'd2;

  always_comb begin
    status_next = '0;
    status_next[0] = 1'b1;
    status_next[1] = status_q[0];
    status_next[2] = flt_write;
    status_next[POS_CT +: 2] = flt_ctx_type;
    status_next[6] = flt_side_eff;
    status_next[POS_CODE +: CODE_W] = flt_code;
    status_next[POS_SPACE +: SPACE_W] = flt_space;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      tag_q    <= '0;
    end else begin
      if (sw_status)      status_q <= reg_wdata;
      else if (flt_pulse) status_q <= status_next;
      if (sw_tag)                     tag_q <= reg_wdata;
      else if (flt_pulse && flt_miss) tag_q <= {flt_addr[AW-1:PAGE_LSB], flt_ctx};
    end
  end

  generate
    if (DATA_SIDE) begin : g_faddr
      always_ff @(posedge clk) begin
        if (!rst_n)         faddr_q <= '0;
        else if (sw_faddr)  faddr_q <= reg_wdata;
        else if (flt_pulse) faddr_q <= flt_addr;
      end
    end else begin : g_no_faddr
      assign faddr_q = '0;
    end
  endgenerate

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = status_q;
      2'd1:    reg_rdata = tag_q;
      2'd2:    reg_rdata = faddr_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pulse && !sw_status |=> status_q[0]) else $error("valid not set"); // R2
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pulse && !sw_status && status_q[0] |=> status_q[1]) else $error("overflow lost"); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pulse && !sw_status |=> !status_q[3] && status_q[AW-1:24] == '0) else $error("stray bits"); // R5
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_pulse && flt_miss) && !sw_tag |=> $stable(tag_q)) else $error("tag moved"); // R6
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_status |=> status_q == $past(reg_wdata)) else $error("sw write lost"); // R9
endmodule

// File: tb/mmu_fault_recorder_test.sv
module mmu_fault_recorder_test;
  logic clk = 0, rst_n = 0;
  logic flt_pulse = 0, flt_write = 0, flt_side_eff = 0, flt_miss = 0;
  logic [1:0] flt_ctx_type = 0;
  logic [6:0] flt_code = 0;
  logic [7:0] flt_space = 0;
  logic [63:0] flt_addr = 0;
  logic [12:0] flt_ctx = 0;
  logic [1:0] reg_sel = 0;
  logic reg_we = 0;
  logic [63:0] reg_wdata = 0, rdata_d, rdata_i;
  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  mmu_fault_recorder uut (.clk, .rst_n, .flt_pulse, .flt_write, .flt_ctx_type, .flt_side_eff,
    .flt_code, .flt_space, .flt_miss, .flt_addr, .flt_ctx, .reg_sel, .reg_we, .reg_wdata,
    .reg_rdata(rdata_d));
  mmu_fault_recorder #(.DATA_SIDE(1'b0)) uut_i (.clk, .rst_n, .flt_pulse, .flt_write,
    .flt_ctx_type, .flt_side_eff, .flt_code, .flt_space, .flt_miss, .flt_addr, .flt_ctx,
    .reg_sel, .reg_we, .reg_wdata, .reg_rdata(rdata_i));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [63:0] stat(bit pend, bit w, logic [1:0] ct, bit se,
                                       logic [6:0] code, logic [7:0] sp);
    logic [63:0] s = '0;
    s[0] = 1; s[1] = pend; s[2] = w; s[5:4] = ct; s[6] = se;
    s[13:7] = code; s[23:16] = sp;
    return s;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] sel, output logic [63:0] d, output logic [63:0] i);
    reg_sel = sel; #1; d = rdata_d; i = rdata_i;
  endtask

  task automatic fault(bit w, logic [1:0] ct, bit se, logic [6:0] code, logic [7:0] sp,
                       bit miss, logic [63:0] a, logic [12:0] cx);
    @(negedge clk);
    flt_pulse = 1; flt_write = w; flt_ctx_type = ct; flt_side_eff = se;
    flt_code = code; flt_space = sp; flt_miss = miss; flt_addr = a; flt_ctx = cx;
    @(negedge clk);
    flt_pulse = 0;
  endtask

  task automatic swr(logic [1:0] sel, logic [63:0] v);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic t_reset;
    logic [63:0] d, i;
    for (int s = 0; s < 3; s++) begin
      rd(s[1:0], d, i);
      check("R1 reset", d, 64'h0);
    end
  endtask

  task automatic t_pair;
    logic [63:0] d, i;
    logic [63:0] a1 = 64'h1234_5678_9ABC_DEF0, a2 = 64'hFEDC_BA98_7654_3210;
    fault(1, 2'd2, 0, 7'h05, 8'h80, 1, a1, 13'h0A5C);
    rd(0, d, i); check("R2 first fault", d, stat(0, 1, 2'd2, 0, 7'h05, 8'h80));
    rd(1, d, i); check("R6 tag on miss", d, (a1 & ~64'h1FFF) | 64'h0A5C);
    rd(2, d, i); check("R7 fault addr", d, a1);
    check("R7 instr side zero", i, 64'h0);
    fault(0, 2'd1, 1, 7'h7F, 8'h2B, 0, a2, 13'h1FFF);
    rd(0, d, i); check("R3 overflow", d, stat(1, 0, 2'd1, 1, 7'h7F, 8'h2B));
    check("R4 fields instr side", i, stat(1, 0, 2'd1, 1, 7'h7F, 8'h2B));
    rd(1, d, i); check("R6 tag held on non-miss", d, (a1 & ~64'h1FFF) | 64'h0A5C);
    rd(2, d, i); check("R7 fault addr second", d, a2);
  endtask

  task automatic t_clean;
    logic [63:0] d, i;
    swr(0, 64'h0);
    rd(0, d, i); check("R8 sw write status", d, 64'h0);
    fault(0, 2'd0, 0, 7'h00, 8'h00, 0, 64'h0, 13'h0);
    rd(0, d, i); check("R4 minimal fields", d, 64'h1);
    swr(0, 64'hFFFF_FFFF_FFFF_FFFE);
    fault(1, 2'd3, 0, 7'h2A, 8'hFF, 0, 64'h40, 13'h1);
    rd(0, d, i); check("R5 stale bits cleared", d, stat(0, 1, 2'd3, 0, 7'h2A, 8'hFF));
    swr(3, 64'hDEAD);
    rd(3, d, i); check("R8 select 3 reads zero", d, 64'h0);
    rd(0, d, i); check("R8 select 3 write ignored", d, stat(0, 1, 2'd3, 0, 7'h2A, 8'hFF));
  endtask

  task automatic t_priority;
    logic [63:0] d, i;
    logic [63:0] a = 64'h0000_7FFF_0000_2000;
    @(negedge clk);
    reg_we = 1; reg_sel = 0; reg_wdata = 64'hA5A5_0000_0000_1234;
    flt_pulse = 1; flt_write = 1; flt_ctx_type = 1; flt_side_eff = 1;
    flt_code = 7'h11; flt_space = 8'h14; flt_miss = 1; flt_addr = a; flt_ctx = 13'h0777;
    @(negedge clk);
    reg_we = 0; flt_pulse = 0;
    rd(0, d, i); check("R9 sw beats fault", d, 64'hA5A5_0000_0000_1234);
    rd(1, d, i); check("R9 tag still updates", d, (a & ~64'h1FFF) | 64'h0777);
    rd(2, d, i); check("R9 faddr still updates", d, a);
    swr(1, 64'h55);
    rd(1, d, i); check("R8 sw write tag", d, 64'h55);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pair();
    t_clean();
    t_priority();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule